// File: doc/BRIEF.md
# Pin Edge Interrupt Collector

This block watches sixteen interrupt lines, each fed from one pin of a general-purpose input port group. Line n always uses pin n, and a small per-line select field picks which of the eight ports that pin comes from. Every port pin is synchronized into the clock domain. Each line can be made sensitive to rising edges, falling edges or both. A detected edge sets a sticky per-line flag.

Flags that are also interrupt-enabled are combined into two registered interrupt requests. One request covers the even-numbered lines and the other covers the odd-numbered lines. Software reaches the select, edge-enable, interrupt-enable, flag and flag-clear registers over a simple word-wide register bus. The bus has a write strobe and a read path with one cycle of latency.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, the rising-enable, falling-enable, interrupt-enable and flag registers read zero, and both interrupt outputs are low.
- R2: When a line's rising-enable bit is set, a low-to-high change on its selected pin sets that line's flag. The flag is visible no later than three clock edges after the change. With only rising enabled, a high-to-low change leaves the flag clear.
- R3: When a line's falling-enable bit is set, a high-to-low change on its selected pin sets the flag. With only falling enabled, a low-to-high change leaves the flag clear.
- R4: With both enables set, either direction of change sets the flag.
- R5: With neither enable set, changes on the pin leave the flag clear.
- R6: Line n takes pin n of port p, where p is the 3-bit field at bits [4k+2:4k] of a select register. Lines 0-7 use select register 0 (address 0), with k = n. Lines 8-15 use select register 1 (address 1), with k = n-8. Bit 4k+3 of each slot reads as zero. Pins of unselected ports never set the flag. gpio_in bit p*16+n is pin n of port p.
- R7: The flag register (address 5) can be read. A flag sets whether or not its interrupt-enable bit is set.
- R8: Writing to address 6 clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R9: When a flag is set and cleared in the same cycle, it ends up set.
- R10: irq_even goes high one cycle after any flag is set with its enable bit set (address 4) on an even line. The enabled-flag mask for even lines is 0x5555. irq_odd does the same for odd lines, with mask 0xAAAA. A flag whose enable bit is clear drives neither output.
- R11: Changing a line's port selection does not set its flag, even when the old and new pins are at different levels.

Register addresses: 0-1 select, 2 rising enable, 3 falling enable, 4 interrupt enable, 5 flags (read), 6 flag clear (write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | 128 | Asynchronous port pins, bit p*16+n is port p pin n |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, for the address of the previous cycle |
| irq_even | output | 1 | Interrupt request for even lines |
| irq_odd | output | 1 | Interrupt request for odd lines |

## Verification
The assertions take for granted that the bus drives no X onto the address or the write strobe while out of reset. They also assume a set pulse and a clear pulse come only from a valid edge and a decoded write to the clear address. The stimulus changes pins and bus signals only on falling clock edges. It holds every pin level for at least four cycles, so each level settles through the synchronizer before the bench samples a flag. The set-versus-clear collision is arranged by counting cycles from the pin change, so that the clear write lands on the edge where the set pulse is active.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int SLOT_W = 4;

  function automatic logic [63:0] alt_mask(input bit odd);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = ((i % 2) == (odd ? 1 : 0));
    return m;
  endfunction
endpackage

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int SEL_W  = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [NLINES-1:0]       flags,
  output logic [NLINES*SEL_W-1:0] sel_flat,
  output logic [NLINES-1:0]       reload,
  output logic [NLINES-1:0]       rise_en,
  output logic [NLINES-1:0]       fall_en,
  output logic [NLINES-1:0]       irq_en,
  output logic [NLINES-1:0]       clr_mask,
  output logic [DATA_W-1:0]       rdata
);
  localparam int LPR    = DATA_W / SLOT_W;
  localparam int NSEL   = (NLINES + LPR - 1) / LPR;
  localparam int A_RISE = NSEL;
  localparam int A_FALL = NSEL + 1;
  localparam int A_IEN  = NSEL + 2;
  localparam int A_FLAG = NSEL + 3;
  localparam int A_CLR  = NSEL + 4;

  logic [SEL_W-1:0]  sel_q [NLINES];
  logic [NLINES-1:0] reload_q, rise_q, fall_q, ien_q;
  logic [DATA_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLINES; i++) sel_q[i] <= '0;
      reload_q <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
      ien_q    <= '0;
    end else begin
      reload_q <= '0;
      for (int i = 0; i < NLINES; i++) begin
        if (wr && addr == ADDR_W'(i / LPR)) begin
          sel_q[i]    <= wdata[(i % LPR)*SLOT_W +: SEL_W];
          reload_q[i] <= 1'b1;
        end
      end
      if (wr && addr == ADDR_W'(A_RISE)) rise_q <= wdata[NLINES-1:0];
      if (wr && addr == ADDR_W'(A_FALL)) fall_q <= wdata[NLINES-1:0];
      if (wr && addr == ADDR_W'(A_IEN))  ien_q  <= wdata[NLINES-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    for (int r = 0; r < NSEL; r++) begin
      if (addr == ADDR_W'(r)) begin
        for (int j = 0; j < LPR; j++) begin
          if (r*LPR + j < NLINES) rd_next[j*SLOT_W +: SEL_W] = sel_q[r*LPR + j];
        end
      end
    end
    if (addr == ADDR_W'(A_RISE)) rd_next[NLINES-1:0] = rise_q;
    if (addr == ADDR_W'(A_FALL)) rd_next[NLINES-1:0] = fall_q;
    if (addr == ADDR_W'(A_IEN))  rd_next[NLINES-1:0] = ien_q;
    if (addr == ADDR_W'(A_FLAG)) rd_next[NLINES-1:0] = flags;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  genvar g;
  generate
    for (g = 0; g < NLINES; g++) begin : g_sel
      assign sel_flat[g*SEL_W +: SEL_W] = sel_q[g];
    end
  endgenerate

  assign reload   = reload_q;
  assign rise_en  = rise_q;
  assign fall_en  = fall_q;
  assign irq_en   = ien_q;
  assign clr_mask = (wr && addr == ADDR_W'(A_CLR)) ? wdata[NLINES-1:0] : '0;

  // R1: enable registers come out of reset cleared
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rise_q == '0 && fall_q == '0 && ien_q == '0));
endmodule

// File: rtl/extint_line.sv
module extint_line #(
  parameter int NPORTS = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] pins,
  input  logic [SEL_W-1:0]  sel,
  input  logic              reload,
  input  logic              rise_en,
  input  logic              fall_en,
  output logic              set
);
  logic [NPORTS-1:0] meta_q, sync_q;
  logic              cur, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pins;
      sync_q <= meta_q;
      prev_q <= cur;
    end
  end

  assign cur = (int'(sel) < NPORTS) ? sync_q[sel] : 1'b0;
  assign set = !reload && ((rise_en && cur && !prev_q) || (fall_en && !cur && prev_q));
endmodule

// File: rtl/extint_flags.sv
module extint_flags
  import extint_pkg::*;
#(
  parameter int NLINES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] set_mask,
  input  logic [NLINES-1:0] clr_mask,
  input  logic [NLINES-1:0] irq_en,
  output logic [NLINES-1:0] flags,
  output logic              irq_even,
  output logic              irq_odd
);
  localparam logic [NLINES-1:0] EVEN_M = NLINES'(alt_mask(1'b0));
  localparam logic [NLINES-1:0] ODD_M  = NLINES'(alt_mask(1'b1));

  logic [NLINES-1:0] flags_q;
  logic [NLINES-1:0] live;

  assign live = flags_q & irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= '0;
      irq_even <= 1'b0;
      irq_odd  <= 1'b0;
    end else begin
      flags_q  <= (flags_q & ~clr_mask) | set_mask;
      irq_even <= |(live & EVEN_M);
      irq_odd  <= |(live & ODD_M);
    end
  end

  assign flags = flags_q;

  // R9: a set pulse always leaves its flag high
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (|set_mask) |=> ((flags_q & $past(set_mask)) == $past(set_mask)));
  // R8: cleared bits without a concurrent set drop
  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (rst)
    (|(clr_mask & ~set_mask)) |=> ((flags_q & $past(clr_mask & ~set_mask)) == '0));
  // R10: requests need an enabled line of matching parity
  assert_even_needs_en_R10: assert property (@(posedge clk) disable iff (rst)
    irq_even |-> $past(|(irq_en & EVEN_M)));
  assert_odd_needs_en_R10: assert property (@(posedge clk) disable iff (rst)
    irq_odd |-> $past(|(irq_en & ODD_M)));
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl #(
  parameter int NLINES = 16,
  parameter int NPORTS = 8,
  parameter int SEL_W  = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORTS*NLINES-1:0] gpio_in,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     irq_even,
  output logic                     irq_odd
);
  logic [NLINES*SEL_W-1:0] sel_flat;
  logic [NLINES-1:0] reload, rise_en, fall_en, irq_en, clr_mask, set_mask, flags;

  extint_regs #(.NLINES(NLINES), .SEL_W(SEL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .flags(flags), .sel_flat(sel_flat), .reload(reload), .rise_en(rise_en),
    .fall_en(fall_en), .irq_en(irq_en), .clr_mask(clr_mask), .rdata(bus_rdata)
  );

  genvar n, p;
  generate
    for (n = 0; n < NLINES; n++) begin : g_line
      logic [NPORTS-1:0] column;
      for (p = 0; p < NPORTS; p++) begin : g_pin
        assign column[p] = gpio_in[p*NLINES + n];
      end
      extint_line #(.NPORTS(NPORTS), .SEL_W(SEL_W)) u_line (
        .clk(clk), .rst(rst), .pins(column), .sel(sel_flat[n*SEL_W +: SEL_W]),
        .reload(reload[n]), .rise_en(rise_en[n]), .fall_en(fall_en[n]),
        .set(set_mask[n])
      );
    end
  endgenerate

  extint_flags #(.NLINES(NLINES)) u_flags (
    .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask),
    .irq_en(irq_en), .flags(flags), .irq_even(irq_even), .irq_odd(irq_odd)
  );
endmodule

// File: tb/tb_extint_ctrl.sv
module tb_extint_ctrl;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] gpio_in = '0;
  logic         bus_wr = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq_even, irq_odd;
  int checks = 0, fails = 0;
  logic [31:0] d;

  extint_ctrl dut (.clk(clk), .rst(rst), .gpio_in(gpio_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_even(irq_even), .irq_odd(irq_odd));

  always #10 clk = ~clk;

  // {port[2:0], line[3:0], rise, fall, from, to, expect}
  localparam logic [11:0] VEC [8] = '{
    {3'd0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R2
    {3'd3, 4'd5,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R2
    {3'd2, 4'd9,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R3
    {3'd7, 4'd15, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R3
    {3'd4, 4'd6,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R4
    {3'd5, 4'd12, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},  // R4
    {3'd1, 4'd3,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R5
    {3'd6, 4'd10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}   // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic pin(input int p, input int n, input logic v);
    gpio_in[p*16 + n] = v;
  endtask

  task automatic set_sel(input int line, input int port);
    wr(3'(line / 8), 32'(port) << ((line % 8) * 4));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wt(3); rst = 1'b0; wt(1);
    // R1 reset state
    rd(3'd2, d); check("R1 rise", d, 0);
    rd(3'd3, d); check("R1 fall", d, 0);
    rd(3'd4, d); check("R1 ien", d, 0);
    rd(3'd5, d); check("R1 flags", d, 0);
    check("R1 irqs", {30'd0, irq_even, irq_odd}, 0);

    for (int k = 0; k < 8; k++) begin
      logic [11:0] v;
      int pt, ln;
      string tag;
      v = VEC[k]; pt = v[11:9]; ln = v[8:5];
      tag = (v[4] && v[3]) ? "R4" : v[4] ? "R2" : v[3] ? "R3" : "R5";
      gpio_in = '0;
      set_sel(ln, pt);
      wr(3'd2, 32'(v[4]) << ln);
      wr(3'd3, 32'(v[3]) << ln);
      pin(pt, ln, v[2]); wt(4);
      wr(3'd6, 32'hFFFF);
      pin(pt, ln, v[1]); wt(3);
      rd(3'd5, d);
      check(tag, 32'(d[ln]), 32'(v[0]));
    end

    // R6 select fields read back 3 bits, fourth bit zero
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); check("R6 lo", d, 32'h7777_7777);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, d); check("R6 hi", d, 32'h7777_7777);
    // R6 unselected port pin ignored
    gpio_in = '0; set_sel(9, 2);
    wr(3'd2, 32'h0200); wr(3'd3, 32'h0200); wt(4); wr(3'd6, 32'hFFFF);
    pin(3, 9, 1'b1); wt(4); rd(3'd5, d); check("R6 other port", d, 0);
    pin(2, 9, 1'b1); wt(4); rd(3'd5, d); check("R6 selected port", d, 32'h0200);
    // R7 flag without enable, irq quiet
    check("R7 irq quiet", {30'd0, irq_even, irq_odd}, 0);
    // R10 odd line enabled
    wr(3'd4, 32'h0200); wt(2);
    check("R10 odd", {30'd0, irq_even, irq_odd}, 32'd1);
    // line 6 on port 0, rise
    set_sel(6, 0); wr(3'd2, 32'h0240); wt(4);
    pin(0, 6, 1'b1); wt(4);
    rd(3'd5, d); check("R7 flags", d, 32'h0240);
    check("R10 even off", {30'd0, irq_even, irq_odd}, 32'd1);
    wr(3'd4, 32'h0040); wt(2);
    check("R10 even only", {30'd0, irq_even, irq_odd}, 32'd2);
    // R8 zero write no effect, one clears
    wr(3'd6, 32'h0); rd(3'd5, d); check("R8 zeros", d, 32'h0240);
    wr(3'd6, 32'h0200); rd(3'd5, d); check("R8 clear", d, 32'h0040);
    wr(3'd6, 32'h0040); wt(2);
    check("R10 drop", {30'd0, irq_even, irq_odd}, 0);

    // R9 set and clear collide
    gpio_in = '0; set_sel(1, 0); wr(3'd2, 32'h0002); wr(3'd3, 32'h0); wt(4);
    wr(3'd6, 32'hFFFF);
    pin(0, 1, 1'b1); wt(2);
    wr(3'd6, 32'h0002);
    rd(3'd5, d); check("R9 set wins", d, 32'h0002);

    // R11 select change creates no edge
    gpio_in = '0; pin(1, 4, 1'b1); set_sel(4, 0);
    wr(3'd2, 32'h0010); wr(3'd3, 32'h0010); wt(4); wr(3'd6, 32'hFFFF);
    set_sel(4, 1); wt(4); rd(3'd5, d); check("R11 to high", d, 0);
    set_sel(4, 0); wt(4); rd(3'd5, d); check("R11 to low", d, 0);
    pin(0, 4, 1'b1); wt(4); rd(3'd5, d); check("R11 real edge", d, 32'h0010);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule